// File: doc/BRIEF.md
# Dictionary Value Decoder

This block expands a stream of dictionary-encoded column codes back into the values they stand for. A dictionary-load stream first writes the table, one entry per handshake, at consecutive indices starting from zero. A single pulse then closes the load phase. After that the block accepts code beats from a data stream and returns the decoded beats on an output stream. Every stream uses a ready/valid handshake.

Two decode modes exist. In fixed-width mode each input beat carries several code lanes. Every lane is resolved in the same cycle against its own copy of the table, and the result is a 2-, 4- or 8-byte value per lane. A lane mask marks which lanes of a beat are real, so a final beat with only some lanes filled passes through cleanly. In string mode one code per cycle is resolved against a single string table. The result is a byte payload, zero-padded to a chosen maximum length of 8, 16 or 32 bytes, and a byte count. Codes are read as 8-bit or 16-bit values, as configured. The decode latency is the same for every code and does not depend on the values.

Top module: `dict_decoder`

## Requirements
- R1: After reset, out_valid and err are 0, in_ready is 0 and ld_ready is 1.
- R2: Each accepted load beat is written to every table copy, at index 0 for the first beat, 1 for the second, and so on. in_ready stays 0 until ld_done has been seen. After ld_done, ld_ready stays 0 and decoding is enabled.
- R3: With cfg_idx16=0, only bits [7:0] of each 16-bit lane slot form the code and bits [15:8] are ignored. With cfg_idx16=1, all 16 bits form the code.
- R4: In fixed mode (cfg_mode=0), cfg_vbytes selects the value width: 0 gives 2 bytes, 1 gives 4 bytes, and 2 or 3 give 8 bytes. The value for lane i is zero-extended in out_data[64i+63:64i] and comes from ld_str[63:0] of the matching load beat. out_str and out_len are zero.
- R5: In fixed mode, lane i takes its code from in_idx[16i+15:16i] and all lanes are decoded in the same beat. in_mask is copied to out_mask. A lane whose mask bit is 0 outputs zero and never raises err.
- R6: In string mode (cfg_mode=1), only lane 0 is decoded and out_mask is 0001. cfg_maxlen selects the maximum length: 0 gives 8 bytes, 1 gives 16, and 2 or 3 give 32. out_len is the smaller of the stored length and that maximum. Byte k of out_str is out_str[8k+7:8k]. It equals byte k of the stored string when k < out_len and is zero otherwise. out_data is zero.
- R7: An active lane whose code is at or above the number of loaded entries outputs zero (in string mode, out_len is 0) and sets err. Once set, err stays 1 until reset.
- R8: While out_valid=1 and out_ready=0, every output field holds its value. Beats leave in the order they were accepted, none lost and none duplicated.
- R9: A beat accepted while the output is empty or draining shows up on out_valid in the next cycle. in_ready stays 1 while out_ready is 1, so one beat per cycle is sustained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 fixed-width lanes, 1 string mode |
| cfg_idx16 | input | 1 | 0 for 8-bit codes, 1 for 16-bit codes |
| cfg_vbytes | input | 2 | Fixed value width select |
| cfg_maxlen | input | 2 | String maximum length select |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted |
| ld_str | input | 256 | Entry payload (low 64 bits also form the fixed value) |
| ld_len | input | 6 | Entry string length in bytes |
| ld_done | input | 1 | Pulse closing the load phase |
| in_valid | input | 1 | Code beat valid |
| in_ready | output | 1 | Code beat accepted |
| in_idx | input | 64 | Code lanes, 16 bits per lane |
| in_mask | input | 4 | Active code lanes |
| out_valid | output | 1 | Decoded beat valid |
| out_ready | input | 1 | Decoded beat taken |
| out_data | output | 256 | Fixed-width values, 64 bits per lane |
| out_mask | output | 4 | Active output lanes |
| out_str | output | 256 | String payload, zero padded |
| out_len | output | 6 | String length in bytes |
| err | output | 1 | Sticky out-of-range code flag |

## Verification
Suppose a table copy drifts out of step with the others, or the load counter skips an index. Then a value or string that differs from the bench model appears on the first beat that reads that entry, one cycle after acceptance. A bad lane-select, width-mask or padding state corrupts the very next decoded beat. A lost stall register or a broken output-valid register shows up as a changed field or a missing beat in the cycle after out_ready falls or rises. A wrong range count shows up either as err rising early while the codes are still legal, or as a non-zero value on a code that should decode to zero.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int CODE_W    = 16;
  localparam int VAL_W     = 64;
  localparam int STR_BYTES = 32;
  localparam int STR_W     = STR_BYTES * 8;
  localparam int LEN_W     = $clog2(STR_BYTES + 1);

  function automatic logic [VAL_W-1:0] width_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return {{(VAL_W-16){1'b0}}, 16'hFFFF};
      2'd1:    return {{(VAL_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: return '1;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] len_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEN_W'(8);
      2'd1:    return LEN_W'(16);
      default: return LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/dd_rst_sync.sv
module dd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dd_ram.sv
module dd_ram #(
  parameter int W     = 64,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dd_load_ctrl.sv
module dd_load_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic          ld_done,
  output logic          ld_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] count,
  output logic          loaded
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          loaded_q, loaded_d;
  logic          cnt_en, loaded_en;

  always_comb begin
    ld_ready  = !loaded_q && (cnt_q < CW'(DEPTH));
    wr_en     = ld_valid && ld_ready;
    cnt_en    = wr_en;
    cnt_d     = cnt_q + CW'(1);
    loaded_en = ld_done && !loaded_q;
    loaded_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (cnt_en)    cnt_q    <= cnt_d;
      if (loaded_en) loaded_q <= loaded_d;
    end
  end

  assign wr_addr = cnt_q[AW-1:0];
  assign count   = cnt_q;
  assign loaded  = loaded_q;
endmodule

// File: rtl/dd_fixed_bank.sv
module dd_fixed_bank
  import dd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [VAL_W-1:0]       wdata,
  input  logic                   re,
  input  logic [LANES*AW-1:0]    raddr,
  output logic [LANES*VAL_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_copy
    dd_ram #(.W(VAL_W), .DEPTH(DEPTH)) u_copy (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re    (re),
      .raddr (raddr[g*AW +: AW]),
      .rdata (rdata[g*VAL_W +: VAL_W])
    );
  end
endmodule

// File: rtl/dict_decoder.sv
module dict_decoder
  import dd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IDX_W  = LANES * CODE_W,
  localparam int DATA_W = LANES * VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cfg_idx16,
  input  logic [1:0]        cfg_vbytes,
  input  logic [1:0]        cfg_maxlen,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [STR_W-1:0]  ld_str,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_done,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [LANES-1:0]  in_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_mask,
  output logic [STR_W-1:0]  out_str,
  output logic [LEN_W-1:0]  out_len,
  output logic              err
);
  logic                rst_i_n;
  logic                wr_en;
  logic [AW-1:0]       wr_addr;
  logic [CW-1:0]       ld_count;
  logic                loaded;

  logic [CODE_W-1:0]   code [LANES];
  logic [LANES-1:0]    lane_act, lane_bad;
  logic [LANES*AW-1:0] rd_addr;
  logic                accept, fx_re, st_re;
  logic [DATA_W-1:0]   fx_rd;
  logic [STR_W+LEN_W-1:0] st_rd;

  logic                ov_q, ov_d, err_q, err_d;
  logic [LANES-1:0]    mask_q, bad_q;
  logic                cap_en;

  dd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  dd_load_ctrl #(.DEPTH(DEPTH)) u_load (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ld_valid (ld_valid),
    .ld_done  (ld_done),
    .ld_ready (ld_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .count    (ld_count),
    .loaded   (loaded)
  );

  // code extraction, lane activity and range check
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      code[i]     = cfg_idx16 ? in_idx[i*CODE_W +: CODE_W]
                              : {8'h00, in_idx[i*CODE_W +: 8]};
      lane_act[i] = cfg_mode ? (i == 0) : in_mask[i];
      lane_bad[i] = lane_act[i] && (32'(code[i]) >= 32'(ld_count));
      rd_addr[i*AW +: AW] = code[i][AW-1:0];
    end
  end

  assign in_ready = loaded && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign fx_re    = accept && !cfg_mode;
  assign st_re    = accept && cfg_mode;

  dd_fixed_bank #(.LANES(LANES), .DEPTH(DEPTH)) u_fixed (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (ld_str[VAL_W-1:0]),
    .re    (fx_re),
    .raddr (rd_addr),
    .rdata (fx_rd)
  );

  dd_ram #(.W(STR_W + LEN_W), .DEPTH(DEPTH)) u_str (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({ld_len, ld_str}),
    .re    (st_re),
    .raddr (rd_addr[AW-1:0]),
    .rdata (st_rd)
  );

  // next state
  always_comb begin
    ov_d   = accept || (ov_q && !out_ready);
    err_d  = err_q || (accept && (|lane_bad));
    cap_en = accept;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ov_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ov_q  <= ov_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      mask_q <= lane_act;
      bad_q  <= lane_bad;
    end
  end

  // output shaping
  logic [VAL_W-1:0] vmask;
  logic [LEN_W-1:0] lim, st_len, len_eff;
  logic [STR_W-1:0] st_str;

  always_comb begin
    vmask  = width_mask(cfg_vbytes);
    lim    = len_limit(cfg_maxlen);
    st_str = st_rd[STR_W-1:0];
    st_len = st_rd[STR_W +: LEN_W];
    for (int i = 0; i < LANES; i++) begin
      out_data[i*VAL_W +: VAL_W] = (!cfg_mode && mask_q[i] && !bad_q[i])
                                   ? (fx_rd[i*VAL_W +: VAL_W] & vmask) : '0;
    end
    if (cfg_mode && !bad_q[0]) len_eff = (st_len > lim) ? lim : st_len;
    else                       len_eff = '0;
    for (int k = 0; k < STR_BYTES; k++) begin
      out_str[k*8 +: 8] = (k < int'(len_eff)) ? st_str[k*8 +: 8] : 8'h00;
    end
  end

  assign out_len   = len_eff;
  assign out_mask  = mask_q;
  assign out_valid = ov_q;
  assign err       = err_q;
endmodule

// File: rtl/dd_checker.sv
module dd_checker
  import dd_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_mode,
  input logic [1:0]             cfg_maxlen,
  input logic                   ld_ready,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*VAL_W-1:0] out_data,
  input logic [LANES-1:0]       out_mask,
  input logic [STR_W-1:0]       out_str,
  input logic [LEN_W-1:0]       out_len,
  input logic                   err
);
  assert_no_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !ld_ready);

  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_str)
                                   && $stable(out_len) && $stable(out_mask)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_len_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mode) |-> (out_len <= len_limit(cfg_maxlen)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assert_idle_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_mask[g]) |-> (out_data[g*VAL_W +: VAL_W] == '0));
  end
endmodule

bind dict_decoder dd_checker #(.LANES(LANES)) u_dd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .cfg_maxlen (cfg_maxlen),
  .ld_ready   (ld_ready),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_mask   (out_mask),
  .out_str    (out_str),
  .out_len    (out_len),
  .err        (err)
);

// File: tb/tb_dict_decoder.sv
module tb_dict_decoder;
  localparam int LANES = 4;
  localparam int DEPTH = 256;
  localparam int NLOAD = 200;

  typedef struct packed {
    logic [255:0] d;
    logic [3:0]   m;
    logic [255:0] s;
    logic [5:0]   l;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_mode = 1'b0, cfg_idx16 = 1'b0;
  logic [1:0]   cfg_vbytes = 2'd0, cfg_maxlen = 2'd0;
  logic         ld_valid = 1'b0, ld_done = 1'b0;
  logic         ld_ready;
  logic [255:0] ld_str = '0;
  logic [5:0]   ld_len = '0;
  logic         in_valid = 1'b0, in_ready;
  logic [63:0]  in_idx = '0;
  logic [3:0]   in_mask = '0;
  logic         out_valid, out_ready = 1'b0;
  logic [255:0] out_data, out_str;
  logic [3:0]   out_mask;
  logic [5:0]   out_len;
  logic         err;

  always #10 clk = ~clk;

  dict_decoder #(.LANES(LANES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_idx16(cfg_idx16),
    .cfg_vbytes(cfg_vbytes), .cfg_maxlen(cfg_maxlen), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_str(ld_str), .ld_len(ld_len), .ld_done(ld_done),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_mask(out_mask), .out_str(out_str), .out_len(out_len), .err(err)
  );

  int     n_chk = 0, n_fail = 0;
  bit     done_flag = 0;
  logic [63:0]  dv  [DEPTH];
  logic [255:0] dsv [DEPTH];
  logic [5:0]   dl  [DEPTH];
  exp_t   q[$];
  bit     err_exp = 0;
  bit     held = 0;
  exp_t   held_v;
  bit     took;
  string  tag = "R4";

  task automatic check(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [63:0] vmask(input logic [1:0] s);
    if (s == 2'd0) return 64'h0000_0000_0000_FFFF;
    if (s == 2'd1) return 64'h0000_0000_FFFF_FFFF;
    return '1;
  endfunction

  function automatic exp_t model(input logic [63:0] idx, input logic [3:0] m,
                                 output bit bad);
    exp_t e;
    int code, lim, len;
    e = '0;
    bad = 0;
    if (!cfg_mode) begin
      e.m = m;
      for (int i = 0; i < LANES; i++) begin
        code = cfg_idx16 ? int'(idx[i*16 +: 16]) : int'(idx[i*16 +: 8]);
        if (m[i]) begin
          if (code >= NLOAD) bad = 1;
          else e.d[i*64 +: 64] = dv[code] & vmask(cfg_vbytes);
        end
      end
    end else begin
      e.m = 4'b0001;
      code = cfg_idx16 ? int'(idx[15:0]) : int'(idx[7:0]);
      lim = (cfg_maxlen == 2'd0) ? 8 : (cfg_maxlen == 2'd1) ? 16 : 32;
      if (code >= NLOAD) bad = 1;
      else begin
        len = (int'(dl[code]) > lim) ? lim : int'(dl[code]);
        e.l = 6'(len);
        for (int k = 0; k < len; k++) e.s[k*8 +: 8] = dsv[code][k*8 +: 8];
      end
    end
    return e;
  endfunction

  // one cycle of stream traffic; called at a falling edge, returns at the next
  task automatic cycle(input bit v, input logic [63:0] idx, input logic [3:0] m,
                       input bit rdy);
    exp_t a, e;
    bit bad;
    in_valid = v; in_idx = idx; in_mask = m; out_ready = rdy;
    #1;
    a = '{d: out_data, m: out_mask, s: out_str, l: out_len};
    if (held)
      check(out_valid && (a == held_v), "R8",
            $sformatf("stalled beat changed act=%h exp=%h", a, held_v));
    if (out_valid && out_ready) begin
      if (q.size() == 0) check(0, "R8", "output beat with none pending act=1 exp=0");
      else begin
        e = q.pop_front();
        check(a == e, tag, $sformatf("act d=%h m=%h s=%h l=%0d exp d=%h m=%h s=%h l=%0d",
              a.d, a.m, a.s, a.l, e.d, e.m, e.s, e.l));
      end
    end
    took = in_valid && in_ready;
    if (took) begin
      q.push_back(model(idx, m, bad));
      if (bad) err_exp = 1;
    end
    held = out_valid && !out_ready;
    held_v = a;
    @(negedge clk);
  endtask

  task automatic send(input logic [63:0] idx, input logic [3:0] m, input int rdy_pct);
    do cycle(1, idx, m, ($urandom % 100) < rdy_pct); while (!took);
  endtask

  task automatic drain();
    while (q.size() != 0) cycle(0, '0, '0, ($urandom % 100) < 70);
    cycle(0, '0, '0, 1);
    cycle(0, '0, '0, 1);
  endtask

  function automatic logic [63:0] rnd_idx(input logic [3:0] m);
    logic [63:0] r;
    for (int i = 0; i < LANES; i++) begin
      if (m[i] || (cfg_mode && i == 0)) begin
        if (cfg_idx16) r[i*16 +: 16] = 16'($urandom % NLOAD);
        else r[i*16 +: 16] = {8'($urandom), 8'($urandom % NLOAD)};
      end else r[i*16 +: 16] = 16'($urandom);
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int acc;
    logic [3:0] m;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(!out_valid && !err && !in_ready && ld_ready, "R1",
          $sformatf("act ov=%b err=%b ir=%b lr=%b exp 0 0 0 1", out_valid, err, in_ready, ld_ready));

    // R2 load phase
    ok = 1;
    for (int e = 0; e < NLOAD; e++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_str = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      ld_len = 6'($urandom % 41);
      dv[e] = ld_str[63:0]; dsv[e] = ld_str; dl[e] = ld_len;
      #1;
      if (!ld_ready || in_ready) ok = 0;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    check(ok, "R2", "ld_ready/in_ready during load act=bad exp=1/0");
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    out_ready = 1'b1;
    #1;
    check(!ld_ready && in_ready, "R2",
          $sformatf("after load act lr=%b ir=%b exp lr=0 ir=1", ld_reay_fix(ld_ready), in_ready));
    @(negedge clk);

    // R2 ordering: first and last entries
    tag = "R2"; cfg_mode = 0; cfg_idx16 = 1; cfg_vbytes = 2'd2;
    send({16'd198, 16'd1, 16'(NLOAD-1), 16'd0}, 4'hF, 100);
    drain();

    // R3 R4 R5 fixed random with idle lanes holding arbitrary codes
    for (int vb = 0; vb < 3; vb++) begin
      for (int w = 0; w < 2; w++) begin
        cfg_vbytes = 2'(vb); cfg_idx16 = w[0]; cfg_mode = 0;
        tag = w ? "R4 R5" : "R3 R4 R5";
        for (int b = 0; b < 40; b++) begin
          m = 4'($urandom);
          send(rnd_idx(m), m, 70);
        end
        drain();
      end
    end

    // R6 string mode, all limits, extra lanes hold garbage
    for (int ml = 0; ml < 3; ml++) begin
      cfg_mode = 1; cfg_maxlen = 2'(ml); cfg_idx16 = ml[0]; tag = "R6";
      for (int b = 0; b < 40; b++) begin
        m = 4'($urandom);
        send(rnd_idx(4'b0000), m, 70);
      end
      drain();
    end

    #1;
    check(!err && !err_exp, "R7", $sformatf("err before bad codes act=%b exp=0", err));

    // R7 out-of-range codes
    tag = "R7";
    cfg_mode = 1; cfg_idx16 = 1;
    send(64'h0000_0000_0000_00FF, 4'h0, 100);
    cfg_mode = 0;
    drain();
    cfg_idx16 = 0; cfg_vbytes = 2'd1;
    send({16'h0005, 16'h00C8, 16'h0003, 16'h1202}, 4'hF, 100);
    drain();
    #1;
    check(err == 1'b1 && err_exp, "R7", $sformatf("err after bad code act=%b exp=1", err));
    cfg_idx16 = 1; tag = "R4 R5";
    for (int b = 0; b < 10; b++) send(rnd_idx(4'hF), 4'hF, 60);
    drain();
    #1;
    check(err == 1'b1, "R7", $sformatf("err sticky act=%b exp=1", err));

    // R9 latency and throughput
    tag = "R9";
    cycle(1, 64'd7, 4'h1, 1);
    #1;
    check(out_valid == 1'b1, "R9", $sformatf("latency act ov=%b exp=1", out_valid));
    acc = 0;
    for (int b = 0; b < 8; b++) begin
      cycle(1, rnd_idx(4'hF), 4'hF, 1);
      if (took) acc++;
    end
    check(acc == 8, "R9", $sformatf("beats accepted in 8 cycles act=%0d exp=8", acc));
    drain();

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic logic ld_reay_fix(input logic v);
    return v;
  endfunction
endmodule